// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block holds a microcontroller core in power-down and brings it back to active operation. Software sends a one-cycle request that stops the oscillator enable and gates the clock to the CPU and its peripherals. While powered down, the block watches three wake sources: a set of external interrupt lines that each count only when configured level-sensitive, a keypad input whose active level is chosen by a polarity bit, and an asynchronous reset pin.

Each source has its own resume rule. An interrupt wake restarts the oscillator but holds the CPU clock off until every qualifying line has been released. A keypad wake restarts the oscillator and then counts a fixed number of oscillator clocks before the CPU clock returns, whether or not the key is still pressed. The reset pin forces the block back to active at once, without a clock edge, and a synchronised reset request follows a few cycles later. An interrupt or keypad wake ends with a one-cycle completion strobe and an interrupt request.

The oscillator is modelled as the `osc_en` output plus a free-running `clk` input.

Top module: `pd_wake_seq`

## Requirements
- R1: After synchronous reset `rst` (with `rst_pin` low), the block is active: `osc_en`=1, `cpu_clk_en`=1, `pd_o`=0, `irq_req`=0, `wake_done`=0, and `rst_req`=0 once `rst_pin` has been low for two edges.
- R2: A `pd_set` pulse while active makes `osc_en`=0, `cpu_clk_en`=0 and `pd_o`=1 from the next rising edge.
- R3: External line i wakes the block only when `ext_irq[i]`=1 (active high) and `ext_level[i]`=1 (level-sensitive). A line with `ext_level[i]`=0 leaves the block powered down.
- R4: On an interrupt wake, `osc_en`=1 from the next edge. `cpu_clk_en` stays 0 while any qualifying line is high, and becomes 1 on the first edge at which all qualifying lines are low.
- R5: The keypad input is active when `kpd_in` equals `kpd_pol` (1 selects high-level trigger, 0 selects low-level trigger).
- R6: On a keypad wake, `osc_en`=1 from the next edge. `cpu_clk_en` returns exactly WAKE_CYC (1024) edges later, even if the key is still held.
- R7: If a qualifying interrupt line and the keypad are both active in power-down, the interrupt resume rule applies.
- R8: `wake_done` and `irq_req` are each high for exactly one cycle, in the first active cycle after an interrupt or keypad wake.
- R9: `rst_pin`=1 sets `osc_en`=1, `cpu_clk_en`=1 and `pd_o`=0 immediately, without a clock edge, and holds the block active while it stays high.
- R10: `rst_req` rises on the second rising edge after `rst_pin` rises, and falls on the second rising edge after it falls.
- R11: `pd_set` has no effect while the block is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high system reset |
| pd_set | input | 1 | Power-down request pulse from software |
| ext_irq | input | N_EXT | External interrupt lines, active high |
| ext_level | input | N_EXT | Per-line level-sensitive configuration |
| kpd_in | input | 1 | Keypad wake input |
| kpd_pol | input | 1 | Keypad trigger level: 1 high, 0 low |
| rst_pin | input | 1 | Asynchronous reset pin |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU and peripheral clock gate enable |
| pd_o | output | 1 | Power-down flag |
| irq_req | output | 1 | Interrupt request after a wake |
| wake_done | output | 1 | One-cycle strobe on return to active |
| rst_req | output | 1 | Synchronised internal reset request |

## Verification
The hardest point to reach from the ports is the last edge of the keypad restart count. The CPU clock must still be off one edge before the count ends and must return on exactly the 1024th edge, with the key held the whole time. The bench enters power-down, presses the key and keeps it pressed. It then checks the clock gate on the 1023rd and 1024th edges after entry into the count. A similar boundary is covered for the interrupt path: a line is held for several cycles, with a stray power-down request in the middle, before it is released.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_PDOWN    = 2'd1,
    ST_WAIT_REL = 2'd2,
    ST_OSC_CNT  = 2'd3
  } pw_state_t;
endpackage

// File: rtl/pd_wake_src.sv
module pd_wake_src #(
  parameter int N_EXT = 2
) (
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_level,
  input  logic             kpd_in,
  input  logic             kpd_pol,
  output logic             int_hit,
  output logic             kpd_hit
);
  logic [N_EXT-1:0] line_ok;

  for (genvar g = 0; g < N_EXT; g++) begin : g_line
    // a line qualifies only in level-sensitive mode
    assign line_ok[g] = ext_irq[g] & ext_level[g];
  end

  assign int_hit = |line_ok;
  assign kpd_hit = ~(kpd_in ^ kpd_pol);
endmodule

// File: rtl/pd_wake_cnt.sv
module pd_wake_cnt #(
  parameter int WAKE_CYC = 1024,
  localparam int CNT_W = $clog2(WAKE_CYC) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en && !done)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CNT_W'(WAKE_CYC - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(WAKE_CYC)); // R6
endmodule

// File: rtl/pd_wake_sync.sv
module pd_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk)
    sh <= {sh[STAGES-2:0], d};

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pd_wake_pkg::*;
#(
  parameter int N_EXT       = 2,
  parameter int WAKE_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_set,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_level,
  input  logic             kpd_in,
  input  logic             kpd_pol,
  input  logic             rst_pin,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             pd_o,
  output logic             irq_req,
  output logic             wake_done,
  output logic             rst_req
);
  pw_state_t st;
  logic      int_hit, kpd_hit, cnt_done, pd_enter;

  pd_wake_src #(.N_EXT(N_EXT)) src_i (
    .ext_irq(ext_irq), .ext_level(ext_level),
    .kpd_in(kpd_in), .kpd_pol(kpd_pol),
    .int_hit(int_hit), .kpd_hit(kpd_hit)
  );

  assign pd_enter = (st == ST_ACTIVE) && pd_set;

  pd_wake_cnt #(.WAKE_CYC(WAKE_CYC)) cnt_i (
    .clk(clk), .rst(rst), .clr(pd_enter),
    .en(st == ST_OSC_CNT), .done(cnt_done)
  );

  pd_wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .d(rst_pin), .q(rst_req)
  );

  // reset pin clears power-down with no clock involved
  always_ff @(posedge clk or posedge rst_pin) begin
    if (rst_pin) begin
      st        <= ST_ACTIVE;
      wake_done <= 1'b0;
      irq_req   <= 1'b0;
    end else if (rst) begin
      st        <= ST_ACTIVE;
      wake_done <= 1'b0;
      irq_req   <= 1'b0;
    end else begin
      wake_done <= 1'b0;
      irq_req   <= 1'b0;
      case (st)
        ST_ACTIVE:   if (pd_set) st <= ST_PDOWN;
        ST_PDOWN: begin
          if (int_hit)      st <= ST_WAIT_REL;
          else if (kpd_hit) st <= ST_OSC_CNT;
        end
        ST_WAIT_REL: if (!int_hit) begin
          st        <= ST_ACTIVE;
          wake_done <= 1'b1;
          irq_req   <= 1'b1;
        end
        ST_OSC_CNT:  if (cnt_done) begin
          st        <= ST_ACTIVE;
          wake_done <= 1'b1;
          irq_req   <= 1'b1;
        end
        default:     st <= ST_ACTIVE;
      endcase
    end
  end

  assign osc_en     = (st != ST_PDOWN);
  assign cpu_clk_en = (st == ST_ACTIVE);
  assign pd_o       = (st == ST_PDOWN);

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (rst || rst_pin)
    (st == ST_WAIT_REL && int_hit) |=> !cpu_clk_en); // R4
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (rst || rst_pin)
    (st == ST_OSC_CNT && !cnt_done) |=> !cpu_clk_en); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst || rst_pin)
    irq_req |=> !irq_req); // R8
  AST_PD_FROM_REQ: assert property (@(posedge clk) disable iff (rst || rst_pin)
    $rose(pd_o) |-> $past(pd_set)); // R2
  AST_PRIO_INT: assert property (@(posedge clk) disable iff (rst || rst_pin)
    (pd_o && int_hit && kpd_hit) |=> (st == ST_WAIT_REL)); // R7
endmodule

// File: tb/pd_wake_seq_tb.sv
module pd_wake_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 1024;

  logic clk = 1'b0, rst = 1'b1, pd_set = 1'b0, kpd_in = 1'b0, kpd_pol = 1'b1, rst_pin = 1'b0;
  logic [1:0] ext_irq = '0, ext_level = '0;
  logic osc_en, cpu_clk_en, pd_o, irq_req, wake_done, rst_req;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_wake_seq dut_i (
    .clk(clk), .rst(rst), .pd_set(pd_set), .ext_irq(ext_irq), .ext_level(ext_level),
    .kpd_in(kpd_in), .kpd_pol(kpd_pol), .rst_pin(rst_pin),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pd_o(pd_o),
    .irq_req(irq_req), .wake_done(wake_done), .rst_req(rst_req)
  );

  // vector: {irq[1:0], lvl[1:0], kpd, pol, exp[1:0]}  exp 0=stay down, 1=int path, 2=keypad path
  localparam logic [7:0] VEC [7] = '{
    {2'b01, 2'b01, 1'b0, 1'b1, 2'd1},
    {2'b10, 2'b00, 1'b0, 1'b1, 2'd0},
    {2'b00, 2'b11, 1'b1, 1'b1, 2'd2},
    {2'b00, 2'b00, 1'b0, 1'b0, 2'd2},
    {2'b00, 2'b11, 1'b1, 1'b0, 2'd0},
    {2'b10, 2'b10, 1'b1, 1'b1, 2'd1},
    {2'b11, 2'b00, 1'b0, 1'b0, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
  endtask

  task automatic go_down();
    pd_set = 1'b1; tick(1); pd_set = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(1);
    do_reset();
    // R1 reset state
    chk({osc_en, cpu_clk_en, pd_o} == 3'b110, "R1 gates", {osc_en, cpu_clk_en, pd_o}, 3'b110);
    chk({irq_req, wake_done, rst_req} == 3'b000, "R1 strobes", {irq_req, wake_done, rst_req}, 0);

    // vector loop: R3 R5 R7
    foreach (VEC[i]) begin
      logic [1:0] ex;
      ex = VEC[i][1:0];
      do_reset();
      kpd_pol = VEC[i][2]; kpd_in = ~VEC[i][2]; ext_irq = '0; ext_level = VEC[i][5:4];
      go_down();
      chk({osc_en, cpu_clk_en, pd_o} == 3'b001, "R2 down", {osc_en, cpu_clk_en, pd_o}, 3'b001);
      ext_irq = VEC[i][7:6]; kpd_in = VEC[i][3];
      tick(1);
      chk({osc_en, cpu_clk_en, pd_o} == ((ex == 0) ? 3'b001 : 3'b100), "R3/R5 wake select",
          {osc_en, cpu_clk_en, pd_o}, (ex == 0) ? 3'b001 : 3'b100);
      ext_irq = '0;
      tick(1);
      chk(cpu_clk_en == (ex == 1), "R7 path", cpu_clk_en, (ex == 1));
      kpd_in = ~kpd_pol;
    end

    // R4 R11 R8: interrupt held, stray pd_set, then release
    do_reset();
    ext_level = 2'b11; kpd_pol = 1'b1; kpd_in = 1'b0;
    go_down();
    ext_irq = 2'b10;
    tick(3);
    pd_set = 1'b1; tick(1); pd_set = 1'b0;
    tick(2);
    chk({osc_en, cpu_clk_en} == 2'b10, "R4 held", {osc_en, cpu_clk_en}, 2'b10);
    ext_irq = '0;
    tick(1);
    chk({cpu_clk_en, pd_o, wake_done, irq_req} == 4'b1011, "R4/R8/R11 release",
        {cpu_clk_en, pd_o, wake_done, irq_req}, 4'b1011);
    tick(1);
    chk({cpu_clk_en, wake_done, irq_req} == 3'b100, "R8 single pulse",
        {cpu_clk_en, wake_done, irq_req}, 3'b100);

    // R6 keypad count with key held
    do_reset();
    ext_level = 2'b00; kpd_pol = 1'b0; kpd_in = 1'b1;
    go_down();
    kpd_in = 1'b0;
    tick(1);
    chk({osc_en, cpu_clk_en} == 2'b10, "R6 osc on", {osc_en, cpu_clk_en}, 2'b10);
    tick(WCYC - 1);
    chk(cpu_clk_en == 1'b0, "R6 before end", cpu_clk_en, 0);
    tick(1);
    chk({cpu_clk_en, wake_done, irq_req} == 3'b111, "R6 end of count",
        {cpu_clk_en, wake_done, irq_req}, 3'b111);
    kpd_in = 1'b1;

    // R9 R10 reset pin
    do_reset();
    go_down();
    tick(2);
    rst_pin = 1'b1;
    #1;
    chk({osc_en, cpu_clk_en, pd_o} == 3'b110, "R9 async", {osc_en, cpu_clk_en, pd_o}, 3'b110);
    tick(1);
    chk(rst_req == 1'b0, "R10 one edge", rst_req, 0);
    tick(1);
    chk(rst_req == 1'b1, "R10 two edges", rst_req, 1);
    pd_set = 1'b1; tick(1); pd_set = 1'b0;
    chk(pd_o == 1'b0, "R9 held active", pd_o, 0);
    rst_pin = 1'b0;
    tick(1);
    chk(rst_req == 1'b1, "R10 fall one edge", rst_req, 1);
    tick(1);
    chk(rst_req == 1'b0, "R10 fall two edges", rst_req, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule